// File: doc/BRIEF.md
# Master Clock Rate Detecting Prescaler

This block measures how many master clock cycles fit between consecutive rising edges of an 8 kHz frame sync. It matches that count against a fixed set of allowed master clock rates and selects the matching ratio. From that ratio it produces two single-cycle enables in the master clock domain: a 256 kHz tick with exactly 32 pulses per frame, and an 8 kHz sample tick at the start of each frame. Both are phase-aligned to the frame sync. When no separate master clock exists, the master clock input may be fed from the serial bit clock.

A rate is adopted only after two back-to-back frame measurements agree. A count that matches no allowed rate flags an error and keeps the previous rate. The block enters standby when the frame sync stays low for too long or when the power-up input is driven low. It leaves standby on the next frame sync rise while the power-up input is high. Rates whose cycle count is not a multiple of 32 spread the remainder with a fractional accumulator, so some tick periods are one cycle longer.

Top module: `clkrate_prescaler`

## Requirements
- R1: While and after reset, `standby`=1, `locked`=0, `tick256`=0, `tick8k`=0, `rate_err`=0 and `rate_sel`=0.
- R2: The frame length is the number of clock cycles between two consecutive rising edges of `fsync`; the width of the high pulse has no effect. Allowed lengths and their `rate_sel` codes: 32→0, 64→1, 192→2, 193→3, 256→4, 320→5, 512→6, 600→7.
- R3: `locked` rises one cycle after the `fsync` rise whose measurement equals the one before it. A valid measurement that differs from the previous one clears `locked` one cycle after that rise. `locked` rising always coincides with `tick8k`.
- R4: While locked to length P, `tick256` pulses exactly 32 times per frame, and only while `locked` is high. The first pulse comes one cycle after the `fsync` rise. Gaps between pulses are floor(P/32) or floor(P/32)+1 cycles, with exactly (P mod 32) of the longer gaps per frame.
- R5: `tick8k` pulses once per locked frame, one cycle after the `fsync` rise, and always together with `tick256`.
- R6: A measured length outside the table sets `rate_err` and clears `locked` one cycle after that rise, with `rate_sel` unchanged. The next valid measurement clears `rate_err` but does not by itself restore `locked`.
- R7: After `fsync` has been low for MISS_LIMIT consecutive cycles (default 640), `standby` is 1 in the following cycle. In standby, `locked`, `tick256` and `tick8k` are 0.
- R8: `pwr_up`=0 sets `standby` in the next cycle. While `pwr_up` stays 0, `fsync` rises neither leave standby nor produce ticks.
- R9: In standby with `pwr_up`=1, an `fsync` rise clears `standby` one cycle later with `locked` still 0. That rise only starts measurement, and lock follows after two more agreeing rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (or bit clock when no master clock is supplied) |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | 8 kHz frame sync, synchronous to clk |
| pwr_up | input | 1 | Power-up request; low forces standby |
| tick256 | output | 1 | 256 kHz single-cycle enable |
| tick8k | output | 1 | 8 kHz single-cycle sample enable at frame start |
| locked | output | 1 | Rate detected and confirmed by two frames |
| standby | output | 1 | Low-power standby state |
| rate_err | output | 1 | Last measured frame length matched no allowed rate |
| rate_sel | output | 3 | Code of the adopted rate (see R2) |

## Verification
Every result of this block is registered. Lock, error, standby exit and the first ticks of a frame therefore appear one clock after the edge that sees the `fsync` rise. Standby appears one clock after the MISS_LIMIT-th low cycle or after `pwr_up` falls. The bench drives inputs on the falling edge and samples on the next falling edge, so each check reads the result of exactly one rising edge. Tick counts and gap lengths are measured over a full P-sample window only after four frames at that length, by which time the rate change, the two-frame confirmation and lock have completed.

// File: rtl/prs_pkg.sv
package prs_pkg;
    localparam int RATE_CNT = 8;
    localparam int SEL_W    = 3;
    localparam int PER_W    = 10;
    localparam int MAX_PER  = 600;

    typedef logic [SEL_W-1:0] rate_sel_t;

    typedef struct packed {
        logic      hit;
        rate_sel_t idx;
    } match_t;

    // Clock cycles per 125 us frame for each rate code
    function automatic logic [PER_W-1:0] rate_period(rate_sel_t s);
        case (s)
            3'd0:    return PER_W'(32);
            3'd1:    return PER_W'(64);
            3'd2:    return PER_W'(192);
            3'd3:    return PER_W'(193);
            3'd4:    return PER_W'(256);
            3'd5:    return PER_W'(320);
            3'd6:    return PER_W'(512);
            default: return PER_W'(600);
        endcase
    endfunction

    function automatic match_t classify(logic [31:0] meas);
        match_t m;
        m = '0;
        for (int i = 0; i < RATE_CNT; i++) begin
            if (meas == 32'(rate_period(rate_sel_t'(i)))) begin
                m.hit = 1'b1;
                m.idx = rate_sel_t'(i);
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/prs_period_meter.sv
module prs_period_meter
    import prs_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fsync,
    output logic   rise,
    output match_t res
);
    logic             fs_q;
    logic [CNT_W-1:0] cnt;

    assign rise = fsync & ~fs_q;
    // cnt holds cycles since the previous rise minus one
    assign res  = classify(32'(cnt) + 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q <= 1'b0;
            cnt  <= '0;
        end else begin
            fs_q <= fsync;
            if (rise)
                cnt <= '0;
            else if (cnt != '1)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/prs_lock_ctrl.sv
module prs_lock_ctrl
    import prs_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int MISS_LIMIT = 640
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwr_up,
    input  logic      fsync,
    input  logic      rise,
    input  match_t    res,
    output logic      stby,
    output logic      lock,
    output logic      lock_nx,
    output rate_sel_t sel,
    output logic      err
);
    localparam logic [CNT_W-1:0] LOW_LAST = CNT_W'(MISS_LIMIT - 1);

    logic             stby_nx, cv, cv_nx, err_nx;
    rate_sel_t        cand, cand_nx, sel_nx;
    logic [CNT_W-1:0] low, low_nx;

    always_comb begin
        stby_nx = stby;
        lock_nx = lock;
        sel_nx  = sel;
        cand_nx = cand;
        cv_nx   = cv;
        err_nx  = err;
        low_nx  = (fsync || stby) ? '0 : low + 1'b1;
        if (!pwr_up) begin
            stby_nx = 1'b1;
            lock_nx = 1'b0;
            cv_nx   = 1'b0;
        end else if (stby) begin
            if (rise) stby_nx = 1'b0;
        end else if (!fsync && low == LOW_LAST) begin
            stby_nx = 1'b1;
            lock_nx = 1'b0;
            cv_nx   = 1'b0;
        end else if (rise) begin
            if (!res.hit) begin
                err_nx  = 1'b1;
                lock_nx = 1'b0;
                cv_nx   = 1'b0;
            end else begin
                err_nx  = 1'b0;
                if (cv && cand == res.idx) begin
                    lock_nx = 1'b1;
                    sel_nx  = res.idx;
                end else begin
                    lock_nx = 1'b0;
                end
                cand_nx = res.idx;
                cv_nx   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stby <= 1'b1;
            lock <= 1'b0;
            sel  <= '0;
            cand <= '0;
            cv   <= 1'b0;
            err  <= 1'b0;
            low  <= '0;
        end else begin
            stby <= stby_nx;
            lock <= lock_nx;
            sel  <= sel_nx;
            cand <= cand_nx;
            cv   <= cv_nx;
            err  <= err_nx;
            low  <= low_nx;
        end
    end
endmodule

// File: rtl/prs_tick_gen.sv
module prs_tick_gen
    import prs_pkg::*;
#(
    parameter int TICKS = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rise,
    input  logic      lock_nx,
    input  rate_sel_t sel,
    output logic      t256,
    output logic      t8k
);
    logic [PER_W-1:0] acc, per;
    logic [PER_W:0]   sum;

    assign per = rate_period(sel);
    assign sum = {1'b0, acc} + (PER_W+1)'(TICKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            t256 <= 1'b0;
            t8k  <= 1'b0;
            acc  <= '0;
        end else if (lock_nx && rise) begin
            t256 <= 1'b1;
            t8k  <= 1'b1;
            acc  <= '0;
        end else if (lock_nx) begin
            t8k <= 1'b0;
            if (sum >= {1'b0, per}) begin
                t256 <= 1'b1;
                acc  <= PER_W'(sum - {1'b0, per});
            end else begin
                t256 <= 1'b0;
                acc  <= sum[PER_W-1:0];
            end
        end else begin
            t256 <= 1'b0;
            t8k  <= 1'b0;
            acc  <= '0;
        end
    end
endmodule

// File: rtl/clkrate_prescaler.sv
module clkrate_prescaler
    import prs_pkg::*;
#(
    parameter int MISS_LIMIT      = 640,
    parameter int TICKS_PER_FRAME = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fsync,
    input  logic       pwr_up,
    output logic       tick256,
    output logic       tick8k,
    output logic       locked,
    output logic       standby,
    output logic       rate_err,
    output logic [2:0] rate_sel
);
    localparam int SPAN  = (MISS_LIMIT > MAX_PER) ? MISS_LIMIT : MAX_PER;
    localparam int CNT_W = $clog2(SPAN + 2);

    logic      rise, lock_nx;
    match_t    res;
    rate_sel_t sel;

    prs_period_meter #(.CNT_W(CNT_W)) i_meter (
        .clk(clk), .rst(rst), .fsync(fsync), .rise(rise), .res(res)
    );

    prs_lock_ctrl #(.CNT_W(CNT_W), .MISS_LIMIT(MISS_LIMIT)) i_ctrl (
        .clk(clk), .rst(rst), .pwr_up(pwr_up), .fsync(fsync), .rise(rise),
        .res(res), .stby(standby), .lock(locked), .lock_nx(lock_nx),
        .sel(sel), .err(rate_err)
    );

    prs_tick_gen #(.TICKS(TICKS_PER_FRAME)) i_ticks (
        .clk(clk), .rst(rst), .rise(rise), .lock_nx(lock_nx), .sel(sel),
        .t256(tick256), .t8k(tick8k)
    );

    assign rate_sel = sel;
endmodule

// File: rtl/prs_checker.sv
module prs_checker (
    input logic       clk,
    input logic       rst,
    input logic       pwr_up,
    input logic       tick256,
    input logic       tick8k,
    input logic       locked,
    input logic       standby,
    input logic       rate_err,
    input logic [2:0] rate_sel
);
    p_tick_locked_r4: assert property (@(posedge clk) disable iff (rst)
        tick256 |-> locked);

    p_sample_tick_r5: assert property (@(posedge clk) disable iff (rst)
        tick8k |-> tick256);

    p_lock_frame_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> tick8k);

    p_err_keeps_sel_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_err) |-> $stable(rate_sel));

    p_standby_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        standby |-> (!locked && !tick256 && !tick8k));

    p_pwrdn_r8: assert property (@(posedge clk) disable iff (rst)
        !pwr_up |=> standby);
endmodule

bind clkrate_prescaler prs_checker i_chk (
    .clk(clk), .rst(rst), .pwr_up(pwr_up), .tick256(tick256), .tick8k(tick8k),
    .locked(locked), .standby(standby), .rate_err(rate_err), .rate_sel(rate_sel)
);

// File: tb/test_clkrate_prescaler.sv
module test_clkrate_prescaler;
    localparam int CLK_PERIOD = 10;
    localparam int MISS       = 640;

    typedef struct packed {
        int per;
        int hi;
        int sel;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32, 1, 0}, '{64, 1, 1}, '{192, 4, 2}, '{193, 1, 3},
        '{256, 20, 4}, '{320, 1, 5}, '{512, 1, 6}, '{600, 30, 7}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fsync = 1'b0;
    logic       pwr_up = 1'b1;
    logic       tick256, tick8k, locked, standby, rate_err;
    logic [2:0] rate_sel;

    int total = 0, bad = 0, cyc = 0;
    int last_tick = -1, n_t = 0, n_s = 0, n_long = 0, gmin = 0, gmax = 0, base = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkrate_prescaler #(.MISS_LIMIT(MISS), .TICKS_PER_FRAME(32)) i_clkrate_prescaler (
        .clk(clk), .rst(rst), .fsync(fsync), .pwr_up(pwr_up),
        .tick256(tick256), .tick8k(tick8k), .locked(locked),
        .standby(standby), .rate_err(rate_err), .rate_sel(rate_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_stats(input int b);
        n_t = 0; n_s = 0; n_long = 0; gmin = 1 << 20; gmax = 0; base = b;
    endtask

    // sample results of the previous edge, then drive fsync for the next one
    task automatic step(input logic fs);
        int gap;
        @(negedge clk);
        cyc++;
        if (tick256) begin
            if (last_tick >= 0) begin
                gap = cyc - last_tick;
                if (gap < gmin) gmin = gap;
                if (gap > gmax) gmax = gap;
                if (gap > base) n_long++;
            end
            n_t++;
            last_tick = cyc;
        end
        if (tick8k) n_s++;
        fsync = fs;
    endtask

    task automatic frame(input int p, input int hi);
        for (int i = 0; i < p; i++) step(i < hi);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 standby", standby, 1);
        chk("R1 locked", locked, 0);
        chk("R1 tick256", tick256, 0);
        chk("R1 tick8k", tick8k, 0);
        chk("R1 rate_err", rate_err, 0);
        chk("R1 rate_sel", rate_sel, 0);
        rst = 1'b0;
        step(1'b0);
        chk("R1 standby after release", standby, 1);

        // table walk: R2 code, R3 lock, R4 tick spacing, R5 sample tick
        foreach (VECS[k]) begin
            for (int f = 0; f < 4; f++) frame(VECS[k].per, VECS[k].hi);
            clr_stats(VECS[k].per / 32);
            frame(VECS[k].per, VECS[k].hi);
            chk($sformatf("R2 rate_sel P=%0d", VECS[k].per), rate_sel, VECS[k].sel);
            chk($sformatf("R3 locked P=%0d", VECS[k].per), locked, 1);
            chk($sformatf("R4 ticks P=%0d", VECS[k].per), n_t, 32);
            chk($sformatf("R4 min gap P=%0d", VECS[k].per), gmin, VECS[k].per / 32);
            chk($sformatf("R4 max gap P=%0d", VECS[k].per), gmax, (VECS[k].per + 31) / 32);
            chk($sformatf("R4 long gaps P=%0d", VECS[k].per), n_long, VECS[k].per % 32);
            chk($sformatf("R5 sample ticks P=%0d", VECS[k].per), n_s, 1);
        end

        // R3: change to 64; second differing rise unlocks, third locks
        frame(64, 1);
        frame(64, 1);
        chk("R3 unlocked on new length", locked, 0);
        chk("R3 no tick while unlocked", tick256, 0);
        step(1'b1); step(1'b0);
        chk("R3 locked on agreement", locked, 1);
        chk("R5 tick8k at lock", tick8k, 1);
        chk("R4 tick256 at lock", tick256, 1);
        chk("R2 rate_sel 64", rate_sel, 1);
        idle(62);

        // R6: invalid length of 100
        frame(100, 1);
        step(1'b1); step(1'b0);
        chk("R6 rate_err set", rate_err, 1);
        chk("R6 locked cleared", locked, 0);
        chk("R6 rate_sel kept", rate_sel, 1);
        idle(62);
        step(1'b1); step(1'b0);
        chk("R6 rate_err cleared", rate_err, 0);
        chk("R6 not yet relocked", locked, 0);
        idle(62);
        step(1'b1); step(1'b0);
        chk("R6 relocked", locked, 1);
        idle(62);

        // R8: power-up pin low
        pwr_up = 1'b0;
        step(1'b0);
        chk("R8 standby on pwr_up low", standby, 1);
        chk("R8 locked cleared", locked, 0);
        clr_stats(2);
        frame(64, 1); frame(64, 1); frame(64, 1);
        chk("R8 still standby", standby, 1);
        chk("R8 no ticks", n_t, 0);
        chk("R8 no sample ticks", n_s, 0);

        // R9: exit on rise with pwr_up high
        pwr_up = 1'b1;
        step(1'b1); step(1'b0);
        chk("R9 standby cleared", standby, 0);
        chk("R9 not locked at exit", locked, 0);
        idle(62);
        step(1'b1); step(1'b0);
        chk("R9 not locked after one frame", locked, 0);
        idle(62);
        step(1'b1); step(1'b0);
        chk("R9 locked after two frames", locked, 1);

        // R7: frame sync missing; previous drive (rise) counts as cycle 0
        for (int j = 2; j <= MISS + 1; j++) begin
            step(1'b0);
            if (j == MISS) chk("R7 no standby before limit", standby, 0);
            if (j == MISS + 1) begin
                chk("R7 standby at limit", standby, 1);
                chk("R7 locked cleared", locked, 0);
                chk("R7 tick256 off", tick256, 0);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule